// File: doc/BRIEF.md
# Per-Processor Prioritised Interrupt Delivery

This unit sits between a set of interrupt sources and one processor. Each source presents an active flag, a 4-bit priority, a vector and a trigger-type flag. The unit records which sources are waiting in a pending set and which ones the processor has taken and not yet finished in an in-service set. It drives one interrupt request line toward the processor.

The request line rises only when the best waiting source outranks both a programmable task-priority threshold and every source already in service. In-service sources therefore hold off equal and lower priorities until they are retired. The processor takes an interrupt with a single-cycle acknowledge strobe, and the vector comes back on the next cycle. It retires the interrupt with a single-cycle end-of-interrupt strobe. When there is nothing to hand out, the acknowledge returns a spurious vector.

Top module: `irq_cpu_deliver`

## Requirements
- R1: After reset the task priority reads 15, both sets are empty, `irq_out` is low and `ack_vld` is low.
- R2: A task-priority write keeps only bits [3:0] of `tpr_wdata`, and the new value appears on `tpr` after the clock edge that takes the write.
- R3: Among pending sources the highest priority is chosen. On a tie the lowest source index wins.
- R4: An active source is recorded as pending even when its priority does not exceed the task priority. Lowering the threshold below that priority then raises `irq_out`.
- R5: `irq_out` is high exactly when the best pending priority is strictly greater than the task priority and strictly greater than the best in-service priority. An empty in-service set counts as priority -1.
- R6: An acknowledge returns the spurious vector 16'hFFFF in two cases: nothing is pending, or the best pending priority is not above the task priority. In that case the in-service set does not change. `ack_vld` is high for one cycle, on the cycle after the strobe, and `ack_vec` is valid in that cycle.
- R7: An acknowledge whose best pending source is above the task priority returns that source's vector and adds the source to the in-service set. `irq_out` is low after it unless a higher-priority source has become pending.
- R8: A source with `src_trig_edge`=1 leaves the pending set when it is acknowledged. Its pending state is latched and survives its active flag dropping. A source with `src_trig_edge`=0 stays pending as long as its active flag is high and leaves when the flag drops.
- R9: An end-of-interrupt strobe removes the highest-priority in-service source. The request line is then re-evaluated: it rises if the best pending priority exceeds both the task priority and what remains in service.
- R10: An end-of-interrupt strobe with an empty in-service set changes nothing.
- R11: An edge-type source becomes pending only on a 0-to-1 transition of its active flag. Holding the flag high after an acknowledge does not make it pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_active | input | NUM_SRC | Per-source active flag |
| src_trig_edge | input | NUM_SRC | 1 = edge-type source, 0 = level-type source |
| src_prio | input | 4*NUM_SRC | Priority of source i at bits [4i+3:4i] |
| src_vec | input | VEC_W*NUM_SRC | Vector of source i at bits [VEC_W*i +: VEC_W] |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data; only [3:0] is kept |
| ack_rd | input | 1 | Single-cycle acknowledge strobe |
| eoi_wr | input | 1 | Single-cycle end-of-interrupt strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| tpr | output | 4 | Current task priority |
| ack_vld | output | 1 | Acknowledge result valid, one cycle after `ack_rd` |
| ack_vec | output | VEC_W | Acknowledged vector, or the spurious vector |

## Verification
The hardest state to reach from the ports has two interrupts nested in service at different priorities while a level source of the higher priority is still asserted. Only in that state does a retire that removes the wrong entry show up as a wrong level on `irq_out`. The stimulus acknowledges a mid-priority source, raises a higher one, acknowledges that too, and then retires once, expecting the request line to rise again. A second hard case is an edge source held active across its own acknowledge and retire. Here the request line must stay low until the flag falls and rises again, and a pending state latched after the flag dropped must still be acknowledged.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int PRIO_W = 4;
    localparam logic [31:0] VEC_MASK = 32'h0000_FFFF;
    localparam logic [PRIO_W-1:0] TPR_RESET = 4'hF;

    typedef logic [PRIO_W-1:0] prio_t;

    // Result of a priority scan; vld=0 stands for "priority -1, no source".
    typedef struct packed {
        logic  vld;
        prio_t prio;
    } rank_t;

    function automatic logic rank_above(rank_t r, prio_t thr);
        return r.vld && (r.prio > thr);
    endfunction

    function automatic logic rank_beats(rank_t a, rank_t b);
        return a.vld && (!b.vld || (a.prio > b.prio));
    endfunction

endpackage

// File: rtl/irqd_pick.sv
module irqd_pick
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        members,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output rank_t                     best,
    output logic [IDX_W-1:0]          best_idx
);

    // Linear scan in ascending index order; a strict compare keeps the
    // lowest index on equal priority.
    always_comb begin
        best     = '0;
        best_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (members[i] &&
                (!best.vld || (prio_flat[i*PRIO_W +: PRIO_W] > best.prio))) begin
                best.vld  = 1'b1;
                best.prio = prio_flat[i*PRIO_W +: PRIO_W];
                best_idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqd_pend.sv
module irqd_pend #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] active,
    input  logic [NUM_SRC-1:0] trig_edge,
    input  logic [NUM_SRC-1:0] ack_clr,
    output logic [NUM_SRC-1:0] pend
);

    logic [NUM_SRC-1:0] act_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_n;
    logic [NUM_SRC-1:0] rise;

    assign rise = active & ~act_q;
    assign pend = pend_q;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            always_comb begin
                if (trig_edge[g]) begin
                    pend_n[g] = (pend_q[g] & ~ack_clr[g]) | rise[g];
                end else begin
                    pend_n[g] = active[g];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            pend_q <= '0;
        end else begin
            act_q  <= active;
            pend_q <= pend_n;
        end
    end

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_clr)); // R7
    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (|(ack_clr & trig_edge & ~rise)) |=>
        ((pend_q & $past(ack_clr & trig_edge & ~rise)) == '0)); // R8
    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(trig_edge)) == ($past(active) & ~$past(trig_edge)))); // R8
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        (|(rise & trig_edge)) |=>
        ((pend_q & $past(rise & trig_edge)) == $past(rise & trig_edge))); // R11

endmodule

// File: rtl/irqd_svc.sv
module irqd_svc #(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] svc
);

    logic [NUM_SRC-1:0] svc_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (set_en) set_vec[set_idx] = 1'b1;
        if (clr_en) clr_vec[clr_idx] = 1'b1;
    end

    // A join in the same cycle as a retire of the same entry keeps it.
    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q <= '0;
        end else begin
            svc_q <= (svc_q & ~clr_vec) | set_vec;
        end
    end

    assign svc = svc_q;

    AST_SVC_JOIN: assert property (@(posedge clk) disable iff (rst)
        set_en |=> svc_q[$past(set_idx)]); // R7
    AST_SVC_LEAVE: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && (set_idx == clr_idx))) |=> !svc_q[$past(clr_idx)]); // R9

endmodule

// File: rtl/irq_cpu_deliver.sv
module irq_cpu_deliver
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_active,
    input  logic [NUM_SRC-1:0]         src_trig_edge,
    input  logic [NUM_SRC*PRIO_W-1:0]  src_prio,
    input  logic [NUM_SRC*VEC_W-1:0]   src_vec,
    input  logic                       tpr_we,
    input  logic [7:0]                 tpr_wdata,
    input  logic                       ack_rd,
    input  logic                       eoi_wr,
    output logic                       irq_out,
    output logic [PRIO_W-1:0]          tpr,
    output logic                       ack_vld,
    output logic [VEC_W-1:0]           ack_vec
);

    localparam logic [VEC_W-1:0] SPUR_VEC = VEC_W'(VEC_MASK);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] svc;
    logic [NUM_SRC-1:0] ack_clr;
    rank_t              pend_best;
    rank_t              svc_best;
    logic [IDX_W-1:0]   pend_idx;
    logic [IDX_W-1:0]   svc_idx;
    logic [VEC_W-1:0]   vec_arr [NUM_SRC];
    prio_t              tpr_q;
    logic               ack_hit;
    logic               eoi_hit;
    logic               ack_vld_q;
    logic [VEC_W-1:0]   ack_vec_q;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
            assign vec_arr[g] = src_vec[g*VEC_W +: VEC_W];
        end
    endgenerate

    irqd_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .active    (src_active),
        .trig_edge (src_trig_edge),
        .ack_clr   (ack_clr),
        .pend      (pend)
    );

    irqd_pick #(.NUM_SRC(NUM_SRC)) u_pick_pend (
        .members   (pend),
        .prio_flat (src_prio),
        .best      (pend_best),
        .best_idx  (pend_idx)
    );

    irqd_pick #(.NUM_SRC(NUM_SRC)) u_pick_svc (
        .members   (svc),
        .prio_flat (src_prio),
        .best      (svc_best),
        .best_idx  (svc_idx)
    );

    // Acknowledge: hand out the best pending source only if it clears the
    // threshold; an edge source is dropped from pending either way.
    assign ack_hit = ack_rd && rank_above(pend_best, tpr_q);
    assign eoi_hit = eoi_wr && svc_best.vld;

    always_comb begin
        ack_clr = '0;
        if (ack_rd && pend_best.vld) ack_clr[pend_idx] = 1'b1;
    end

    irqd_svc #(.NUM_SRC(NUM_SRC)) u_svc (
        .clk     (clk),
        .rst     (rst),
        .set_en  (ack_hit),
        .set_idx (pend_idx),
        .clr_en  (eoi_hit),
        .clr_idx (svc_idx),
        .svc     (svc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tpr_q     <= TPR_RESET;
            ack_vld_q <= 1'b0;
            ack_vec_q <= SPUR_VEC;
        end else begin
            if (tpr_we) tpr_q <= tpr_wdata[PRIO_W-1:0];
            ack_vld_q <= ack_rd;
            if (ack_rd) ack_vec_q <= ack_hit ? vec_arr[pend_idx] : SPUR_VEC;
        end
    end

    assign irq_out = rank_above(pend_best, tpr_q) && rank_beats(pend_best, svc_best);
    assign tpr     = tpr_q;
    assign ack_vld = ack_vld_q;
    assign ack_vec = ack_vec_q;

    AST_ACK_VLD_NEXT: assert property (@(posedge clk) disable iff (rst)
        ack_rd |=> ack_vld); // R6
    AST_SPUR_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !pend_best.vld) |=> (ack_vec == SPUR_VEC)); // R6
    AST_TPR_LOW4: assert property (@(posedge clk) disable iff (rst)
        tpr_we |=> (tpr == $past(tpr_wdata & 8'h0F))); // R2
    AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && (svc == '0) && !ack_hit) |=> (svc == '0)); // R10
    AST_IRQ_QUIET_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !eoi_wr && ((src_active & ~$past(src_active)) == '0)) |=> !irq_out); // R7

endmodule

// File: tb/tb_irq_cpu_deliver.sv
module tb_irq_cpu_deliver;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int VW = 16;
    localparam int NSTEP = 15;

    // {act[15:0], tpr_we, tpr_data[7:0], ack, eoi, exp_irq, exp_ackv, exp_vec[15:0]}
    localparam logic [44:0] TBL [NSTEP] = '{
        {16'h0008, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
        {16'h0008, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA003},
        {16'h0108, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
        {16'h0108, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA008},
        {16'h0108, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000},
        {16'h0108, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000},
        {16'h0C00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
        {16'h0C00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA00A},
        {16'h0C00, 1'b1, 8'h25, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
        {16'h0C00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
        {16'h0C00, 1'b1, 8'hF4, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
        {16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA00A},
        {16'h0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF},
        {16'h0000, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
        {16'h0000, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      src_active = '0;
    logic [N-1:0]      src_trig_edge = '0;
    logic [N*4-1:0]    src_prio;
    logic [N*VW-1:0]   src_vec;
    logic              tpr_we = 1'b0;
    logic [7:0]        tpr_wdata = '0;
    logic              ack_rd = 1'b0;
    logic              eoi_wr = 1'b0;
    logic              irq_out;
    logic [3:0]        tpr;
    logic              ack_vld;
    logic [VW-1:0]     ack_vec;

    int n_chk = 0;
    int n_fail = 0;
    logic s_irq, s_av;
    logic [VW-1:0] s_vec;
    logic [3:0] s_tpr;

    // Source i: priority i/2, vector 16'hA000 + i
    generate
        for (genvar g = 0; g < N; g++) begin : g_cfg
            assign src_prio[g*4 +: 4]  = 4'(g / 2);
            assign src_vec[g*VW +: VW] = 16'hA000 + 16'(g);
        end
    endgenerate

    irq_cpu_deliver #(.NUM_SRC(N), .VEC_W(VW)) dut (
        .clk(clk), .rst(rst), .src_active(src_active), .src_trig_edge(src_trig_edge),
        .src_prio(src_prio), .src_vec(src_vec), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .ack_rd(ack_rd), .eoi_wr(eoi_wr), .irq_out(irq_out), .tpr(tpr),
        .ack_vld(ack_vld), .ack_vec(ack_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle of stimulus; outputs captured just after the edge.
    task automatic step(input logic [N-1:0] act, input logic twe, input logic [7:0] tdat,
                        input logic ack, input logic eoi);
        @(negedge clk);
        src_active = act;
        tpr_we = twe;
        tpr_wdata = tdat;
        ack_rd = ack;
        eoi_wr = eoi;
        @(posedge clk);
        #1;
        s_irq = irq_out;
        s_av  = ack_vld;
        s_vec = ack_vec;
        s_tpr = tpr;
        tpr_we = 1'b0;
        ack_rd = 1'b0;
        eoi_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        src_active = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        chk("R1 tpr reset", 32'(tpr), 32'hF);
        chk("R1 irq reset", 32'(irq_out), 32'h0);
        chk("R1 ack_vld reset", 32'(ack_vld), 32'h0);
        step('0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 empty ack valid", 32'(s_av), 32'h1);
        chk("R6 empty ack spurious", 32'(s_vec), 32'hFFFF);
        step('0, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R6 ack_vld one cycle", 32'(s_av), 32'h0);

        // Table walk, all level sources
        for (int k = 0; k < NSTEP; k++) begin
            step(TBL[k][44:29], TBL[k][28], TBL[k][27:20], TBL[k][19], TBL[k][18]);
            chk($sformatf("R5 table step %0d irq", k), 32'(s_irq), 32'(TBL[k][17]));
            chk($sformatf("R6 table step %0d ack_vld", k), 32'(s_av), 32'(TBL[k][16]));
            if (TBL[k][16])
                chk($sformatf("R3 R7 table step %0d vector", k), 32'(s_vec), 32'(TBL[k][15:0]));
        end

        // R2: only low 4 bits kept
        step('0, 1'b1, 8'hA7, 1'b0, 1'b0);
        chk("R2 tpr low bits", 32'(s_tpr), 32'h7);
        step('0, 1'b1, 8'h3C, 1'b0, 1'b0);
        chk("R2 tpr low bits", 32'(s_tpr), 32'hC);

        // R4: below-threshold source still pending
        step(16'h8000, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R4 gated by tpr", 32'(s_irq), 32'h0);
        step(16'h8000, 1'b1, 8'h06, 1'b0, 1'b0);
        chk("R4 fires after lowering tpr", 32'(s_irq), 32'h1);

        // Edge source 5 (priority 2)
        do_reset();
        src_trig_edge = 16'h0020;
        step(16'h0000, 1'b1, 8'h00, 1'b0, 1'b0);
        step(16'h0020, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R11 rise pends", 32'(s_irq), 32'h1);
        step(16'h0020, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R7 edge ack vector", 32'(s_vec), 32'hA005);
        chk("R7 irq low after ack", 32'(s_irq), 32'h0);
        step(16'h0020, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R11 held high no re-pend", 32'(s_irq), 32'h0);
        step(16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
        step(16'h0020, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R11 second rise pends", 32'(s_irq), 32'h1);
        step(16'h0000, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R8 edge pend latched after drop", 32'(s_vec), 32'hA005);
        step(16'h0000, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R8 edge removed from pending", 32'(s_irq), 32'h0);
        src_trig_edge = '0;

        // Level source 6 (priority 3) stays pending
        step(16'h0040, 1'b0, 8'h00, 1'b0, 1'b0);
        step(16'h0040, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R7 level ack vector", 32'(s_vec), 32'hA006);
        step(16'h0040, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R8 level still pending after retire", 32'(s_irq), 32'h1);
        step(16'h0000, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R8 level drops with flag", 32'(s_irq), 32'h0);

        // R10: retire with nothing in service
        step(16'h0040, 1'b0, 8'h00, 1'b0, 1'b0);
        step(16'h0040, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R10 empty retire keeps irq", 32'(s_irq), 32'h1);
        step(16'h0040, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R10 empty retire keeps pending", 32'(s_vec), 32'hA006);
        step(16'h0000, 1'b0, 8'h00, 1'b0, 1'b1);

        // Nesting: tie, higher source, retire order
        step(16'h3002, 1'b0, 8'h00, 1'b0, 1'b0);
        step(16'h3002, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R3 tie lowest index", 32'(s_vec), 32'hA00C);
        step(16'h7002, 1'b0, 8'h00, 1'b0, 1'b0);
        chk("R5 higher than in-service fires", 32'(s_irq), 32'h1);
        step(16'h7002, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R7 nested ack vector", 32'(s_vec), 32'hA00E);
        chk("R5 nested irq low", 32'(s_irq), 32'h0);
        step(16'h7002, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R9 retire highest then reassert", 32'(s_irq), 32'h1);
        step(16'h0002, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R5 priority 0 never above tpr 0", 32'(s_irq), 32'h0);
        step(16'h0002, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 not above tpr gives spurious", 32'(s_vec), 32'hFFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule